// File: doc/BRIEF.md
# Low-Voltage Supply Status Controller

This block is the digital half of a supply-voltage monitor. Two analog comparators outside the block report whether the supply is under a falling trip level and whether it is over a rising trip level. The block brings both results into its clock domain through a two-flop synchronizer. From them it keeps a single low-voltage flag with hysteresis. It returns that flag in a read-only status byte on a simple register bus, and it raises a system reset request when that request is configured.

Three configuration bits control the block: a power-down bit, a stop-keep-alive bit and a reset-enable bit. Two mode inputs tell it whether the system is in wait or stop. Monitoring continues through wait mode. It survives stop mode only when power-down is clear and stop-keep-alive is set. While monitoring is inactive, the flag is frozen and the reset request is held low. The block has an interrupt output, and that output is permanently idle.

Top module: `lvi_status_ctrl`

## Requirements
- R1: When the synchronized under-falling-level input is high and monitoring is active, the flag becomes 1 on that clock edge.
- R2: When the synchronized over-rising-level input is high, the under-falling-level input is low and monitoring is active, the flag becomes 0.
- R3: When neither synchronized comparator input is high, the flag keeps its previous value.
- R4: When both synchronized comparator inputs are high at once, the under-falling-level input wins and the flag becomes 1.
- R5: A synchronous reset (rst high at a clock edge) clears the flag, both synchronizer stages, the reset request and the read data.
- R6: A read strobe at address 0xFE0C loads the read data on the next edge. Bit 7 holds the flag and bits 6..0 are 0. A read at any other address, or no read, loads 0x00.
- R7: The status byte is read-only, and reading it never changes the flag.
- R8: The interrupt output is 0 at all times.
- R9: The reset request is 1 in the cycle after an edge at which the flag was 1, monitoring was active and reset-enable was set. With reset-enable clear the flag still updates but no request is issued.
- R10: While power-down is set, the flag is frozen and the reset request is 0.
- R11: In stop mode, monitoring is active only if power-down is clear and stop-keep-alive is set. Otherwise the flag is frozen and the request is 0. Stop takes precedence over wait when both mode inputs are high.
- R12: In wait mode, monitoring stays active whenever power-down is clear, so an enabled request can still be raised.
- R13: A comparator change applied before edge E1 passes through synchronizer stages at E1 and E2 and reaches the flag at E3. The flag's new value first appears on the read data at E4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_under_fall_i | input | 1 | Comparator: supply under falling trip level (asynchronous) |
| cmp_over_rise_i | input | 1 | Comparator: supply over rising trip level (asynchronous) |
| cfg_pwrdn_i | input | 1 | Power-down of the monitor |
| cfg_stop_keep_i | input | 1 | Keep monitoring alive in stop mode |
| cfg_rst_en_i | input | 1 | Allow a reset request |
| mode_wait_i | input | 1 | System is in wait mode |
| mode_stop_i | input | 1 | System is in stop mode |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Read address |
| bus_rdata_o | output | DATA_W | Registered read data |
| rst_req_o | output | 1 | Registered system reset request |
| irq_o | output | 1 | Interrupt request, always 0 |

## Verification
The flag is internal, so a wrong value can only show at the ports in two places. It appears on the read data one edge after a read strobe, and on the reset request one edge after the faulty flag edge. A wrong synchronizer depth shifts every flag change by whole cycles, and the per-cycle comparison catches that within one edge. A wrong activity decision shows in two ways: a flag that moves while the monitor should be frozen, which shows on the next status read, or a request that rises in a gated mode on the following edge.

// File: rtl/lvi_pkg.sv
package lvi_pkg;

  // Low-power mode as seen by the monitor; stop dominates wait.
  typedef enum logic [1:0] {
    LP_RUN  = 2'd0,
    LP_WAIT = 2'd1,
    LP_STOP = 2'd2
  } lp_mode_e;

  typedef struct packed {
    logic pwrdn;
    logic stop_keep;
    logic rst_en;
  } lvi_cfg_t;

  typedef struct packed {
    logic under_fall;
    logic over_rise;
  } lvi_cmp_t;

  localparam int CMP_W = $bits(lvi_cmp_t);

endpackage

// File: rtl/lvi_sync.sv
module lvi_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[LAST];

endmodule

// File: rtl/lvi_mode_gate.sv
module lvi_mode_gate
  import lvi_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  lvi_cfg_t cfg_i,
  input  logic     wait_i,
  input  logic     stop_i,
  input  logic     flag_i,
  output logic     active_o,
  output logic     rst_req_o
);

  lp_mode_e mode;
  logic     req_q;

  always_comb begin
    if (stop_i)      mode = LP_STOP;
    else if (wait_i) mode = LP_WAIT;
    else             mode = LP_RUN;
  end

  always_comb begin
    unique case (mode)
      LP_RUN:  active_o = !cfg_i.pwrdn;
      LP_WAIT: active_o = !cfg_i.pwrdn;
      LP_STOP: active_o = !cfg_i.pwrdn && cfg_i.stop_keep;
      default: active_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= active_o && cfg_i.rst_en && flag_i;
  end

  assign rst_req_o = req_q;

endmodule

// File: rtl/lvi_hyst.sv
module lvi_hyst (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic under_fall_i,
  input  logic over_rise_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (active_i) begin
      if (under_fall_i)     flag_q <= 1'b1;
      else if (over_rise_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/lvi_regif.sv
module lvi_regif #(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFE0C,
  parameter int              FLAG_POS  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] status_byte;
  logic [DATA_W-1:0] rdata_q;
  logic              hit;

  assign hit = rd_i && (addr_i == BASE_ADDR);

  always_comb begin
    status_byte           = '0;
    status_byte[FLAG_POS] = flag_i;
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata_q <= '0;
    else if (hit) rdata_q <= status_byte;
    else          rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/lvi_status_ctrl.sv
module lvi_status_ctrl
  import lvi_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              DATA_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'hFE0C,
  parameter int              FLAG_POS    = 7,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_under_fall_i,
  input  logic              cmp_over_rise_i,
  input  logic              cfg_pwrdn_i,
  input  logic              cfg_stop_keep_i,
  input  logic              cfg_rst_en_i,
  input  logic              mode_wait_i,
  input  logic              mode_stop_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              rst_req_o,
  output logic              irq_o
);

  lvi_cmp_t cmp_raw;
  lvi_cmp_t cmp_sync;
  lvi_cfg_t cfg;
  logic     active;
  logic     flag;

  assign cmp_raw.under_fall = cmp_under_fall_i;
  assign cmp_raw.over_rise  = cmp_over_rise_i;
  assign cfg.pwrdn          = cfg_pwrdn_i;
  assign cfg.stop_keep      = cfg_stop_keep_i;
  assign cfg.rst_en         = cfg_rst_en_i;

  lvi_sync #(
    .WIDTH  (CMP_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (cmp_raw),
    .q_o (cmp_sync)
  );

  lvi_mode_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .cfg_i     (cfg),
    .wait_i    (mode_wait_i),
    .stop_i    (mode_stop_i),
    .flag_i    (flag),
    .active_o  (active),
    .rst_req_o (rst_req_o)
  );

  lvi_hyst u_hyst (
    .clk          (clk),
    .rst          (rst),
    .active_i     (active),
    .under_fall_i (cmp_sync.under_fall),
    .over_rise_i  (cmp_sync.over_rise),
    .flag_o       (flag)
  );

  lvi_regif #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR),
    .FLAG_POS  (FLAG_POS)
  ) u_regif (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (bus_rd_i),
    .addr_i  (bus_addr_i),
    .flag_i  (flag),
    .rdata_o (bus_rdata_o)
  );

  assign irq_o = 1'b0;

endmodule

// File: rtl/lvi_status_ctrl_chk.sv
module lvi_status_ctrl_chk #(
  parameter int DATA_W   = 8,
  parameter int FLAG_POS = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_pwrdn_i,
  input logic              cfg_stop_keep_i,
  input logic              cfg_rst_en_i,
  input logic              mode_stop_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              rst_req_o,
  input logic              irq_o,
  input logic              active,
  input logic              flag,
  input logic              sync_fall,
  input logic              sync_rise
);

  p_irq_idle_r8: assert property (@(posedge clk) irq_o == 1'b0);

  p_fall_sets_r1: assert property (@(posedge clk) disable iff (rst)
    (active && sync_fall) |=> flag);

  p_rise_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (active && sync_rise && !sync_fall) |=> !flag);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!sync_fall && !sync_rise) |=> $stable(flag));

  p_reset_clears_r5: assert property (@(posedge clk)
    rst |=> (!flag && !rst_req_o && bus_rdata_o == '0));

  // R6: only the flag position may be non-zero in the read data.
  p_rdata_fmt_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata_o & ~(DATA_W'(1) << FLAG_POS)) == '0);

  p_req_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> $past(cfg_rst_en_i && flag));

  p_pwrdn_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_pwrdn_i |=> ($stable(flag) && !rst_req_o));

  p_stop_gate_r11: assert property (@(posedge clk) disable iff (rst)
    (mode_stop_i && !cfg_stop_keep_i) |=> ($stable(flag) && !rst_req_o));

endmodule

bind lvi_status_ctrl lvi_status_ctrl_chk #(
  .DATA_W   (DATA_W),
  .FLAG_POS (FLAG_POS)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cfg_pwrdn_i     (cfg_pwrdn_i),
  .cfg_stop_keep_i (cfg_stop_keep_i),
  .cfg_rst_en_i    (cfg_rst_en_i),
  .mode_stop_i     (mode_stop_i),
  .bus_rdata_o     (bus_rdata_o),
  .rst_req_o       (rst_req_o),
  .irq_o           (irq_o),
  .active          (active),
  .flag            (flag),
  .sync_fall       (cmp_sync.under_fall),
  .sync_rise       (cmp_sync.over_rise)
);

// File: tb/lvi_status_ctrl_tb.sv
module lvi_status_ctrl_tb;

  localparam logic [15:0] ADDR_STATUS = 16'hFE0C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fall = 1'b0, rise = 1'b0;
  logic        pwrdn = 1'b0, keep = 1'b0, ren = 1'b1;
  logic        mwait = 1'b0, mstop = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  rdata;
  logic        req, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lvi_status_ctrl u_dut (
    .clk              (clk),
    .rst              (rst),
    .cmp_under_fall_i (fall),
    .cmp_over_rise_i  (rise),
    .cfg_pwrdn_i      (pwrdn),
    .cfg_stop_keep_i  (keep),
    .cfg_rst_en_i     (ren),
    .mode_wait_i      (mwait),
    .mode_stop_i      (mstop),
    .bus_rd_i         (rd),
    .bus_addr_i       (addr),
    .bus_rdata_o      (rdata),
    .rst_req_o        (req),
    .irq_o            (irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: delay lines as queues, flag and outputs as plain bits.
  bit qf[$] = '{1'b0, 1'b0};
  bit qr[$] = '{1'b0, 1'b0};
  bit m_flag = 1'b0, m_req = 1'b0;
  logic [7:0] m_rdata = 8'h00;

  always @(posedge clk) begin
    bit act, df, dr;
    if (rst) begin
      qf = '{1'b0, 1'b0};
      qr = '{1'b0, 1'b0};
      m_flag = 1'b0; m_req = 1'b0; m_rdata = 8'h00;
    end else begin
      act = !pwrdn && !(mstop && !keep);
      m_req = act && ren && m_flag;
      m_rdata = (rd && addr == ADDR_STATUS) ? {m_flag, 7'b0} : 8'h00;
      df = qf.pop_front(); dr = qr.pop_front();
      qf.push_back(fall); qr.push_back(rise);
      if (act) begin
        if (df)      m_flag = 1'b1;
        else if (dr) m_flag = 1'b0;
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      check(req == m_req, "R9 model rst_req", req, m_req);
      check(rdata == m_rdata, "R6 model rdata", rdata, m_rdata);
      check(irq == 1'b0, "R8 irq idle", irq, 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_at(input logic [15:0] a, output logic [7:0] v);
    addr = a; rd = 1'b1;
    @(negedge clk);
    v = rdata;
    rd = 1'b0; addr = 16'h0000;
  endtask

  task automatic expect_status(input logic [7:0] exp, input string tag);
    logic [7:0] v;
    read_at(ADDR_STATUS, v);
    check(v == exp, tag, v, exp);
  endtask

  initial begin
    logic [7:0] v;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R5: state after reset
    expect_status(8'h00, "R5 status after reset");
    check(req == 1'b0, "R5 req after reset", req, 0);

    // R13: change reaches flag at E3, read data at E4
    fall = 1'b1;
    tick(2);
    addr = ADDR_STATUS; rd = 1'b1;
    @(negedge clk); v = rdata;
    check(v == 8'h00, "R13 flag not yet visible", v, 8'h00);
    @(negedge clk); v = rdata;
    check(v == 8'h80, "R13 flag visible at E4", v, 8'h80);
    rd = 1'b0; addr = 16'h0000;
    tick(3);
    expect_status(8'h80, "R1 under-fall sets flag");
    check(req == 1'b1, "R9 enabled request", req, 1);

    // R3 hold
    fall = 1'b0; rise = 1'b0; tick(5);
    expect_status(8'h80, "R3 hold between levels");
    expect_status(8'h80, "R7 read does not disturb flag");

    // R2 clear
    rise = 1'b1; tick(5);
    expect_status(8'h00, "R2 over-rise clears flag");
    check(req == 1'b0, "R2 request drops", req, 0);

    // R4 both high
    fall = 1'b1; tick(5);
    expect_status(8'h80, "R4 under-fall has priority");
    fall = 1'b0; tick(5);
    expect_status(8'h00, "R2 clear after priority case");

    // R9 reset-enable clear
    ren = 1'b0; rise = 1'b0; fall = 1'b1; tick(5);
    expect_status(8'h80, "R9 flag updates without enable");
    check(req == 1'b0, "R9 no request without enable", req, 0);
    ren = 1'b1; tick(3);
    check(req == 1'b1, "R9 request after enable", req, 1);

    // R10 power-down freeze
    pwrdn = 1'b1; fall = 1'b0; rise = 1'b1; tick(5);
    expect_status(8'h80, "R10 flag frozen in power-down");
    check(req == 1'b0, "R10 request low in power-down", req, 0);
    pwrdn = 1'b0; tick(5);
    expect_status(8'h00, "R10 updates after power-down");

    // R11 stop gating (stop dominates wait)
    mstop = 1'b1; mwait = 1'b1; keep = 1'b0; rise = 1'b0; fall = 1'b1; tick(5);
    expect_status(8'h00, "R11 frozen in stop without keep");
    check(req == 1'b0, "R11 request low in stop", req, 0);
    keep = 1'b1; tick(5);
    expect_status(8'h80, "R11 active in stop with keep");
    check(req == 1'b1, "R11 request in stop with keep", req, 1);
    mstop = 1'b0; keep = 1'b0;

    // R12 wait mode stays active
    fall = 1'b0; rise = 1'b1; tick(5);
    expect_status(8'h00, "R12 clears in wait");
    rise = 1'b0; fall = 1'b1; tick(5);
    check(req == 1'b1, "R12 request in wait", req, 1);
    mwait = 1'b0;

    // R6 other address
    read_at(16'hFE0D, v);
    check(v == 8'h00, "R6 other address reads zero", v, 8'h00);
    expect_status(8'h80, "R6 flag at bit 7");

    // R5 reset with flag set
    rst = 1'b1; fall = 1'b0; tick(2);
    rst = 1'b0; tick(1);
    check(req == 1'b0, "R5 request cleared by reset", req, 0);
    expect_status(8'h00, "R5 flag cleared by reset");

    tick(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule